// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Threshold Loader

This block keeps the two threshold offsets that a FIFO uses to warn that it is nearly drained or nearly filled. It compares the FIFO's fill count against those offsets and drives two active-low flags. The almost-empty offset is counted in words up from the empty boundary. The almost-full offset is counted in words down from the full boundary. The FIFO storage and its pointers sit outside the block, which sees only the fill count.

The load pin has two roles. While master reset is held, its level is captured. That level sets the reset value of both offsets and fixes the only programming path that the block accepts until the next master reset. One path shifts bits in from a serial pin. The other writes whole words from a parallel bus. After reset, driving the load pin low opens access to the offsets. Whichever path was selected, the offsets can be read back only over the parallel output bus.

Top module: `afl_offset_loader`

## Requirements
- R1: If `ld_n` is 0 on a clock edge with `mrs_n` low, both offsets reset to 127 and the parallel path becomes the only write path.
- R2: If `ld_n` is 1 on a clock edge with `mrs_n` low, both offsets reset to 1023 and the serial path becomes the only write path.
- R3: In serial mode, each rising `clk` edge with `sen_n`=0 and `ld_n`=0 stores `sdi` as the next offset bit. The first OFS_W bits fill the almost-empty offset, least significant bit first. The next OFS_W bits fill the almost-full offset, also least significant bit first.
- R4: In serial mode, an edge with `sen_n`=1 leaves both offsets unchanged, whatever `sdi` does.
- R5: In serial mode, serial bits after the first 2*OFS_W are ignored.
- R6: In parallel mode, an edge with `ld_n`=0 and `wr_en`=1 writes `din` into the next offset. Writes go to the almost-empty offset, then the almost-full offset, and the order repeats. With `ld_n`=1, `wr_en` has no effect.
- R7: Writes through the path that was not selected at reset have no effect. This covers parallel writes in serial mode and serial bits in parallel mode.
- R8: An edge with `ld_n`=0 and `rd_en`=1 loads `q` with the next offset, one cycle later. Reads go to the almost-empty offset, then the almost-full offset, and the order repeats. `q` holds its value on all other edges.
- R9: One cycle after `fill` is presented, `ae_n` is 0 if `fill` is less than or equal to the almost-empty offset, and 1 otherwise.
- R10: One cycle after `fill` is presented, `af_n` is 0 if `fill` is greater than or equal to DEPTH minus the almost-full offset, and 1 otherwise.
- R11: After a master reset, `ae_n`=0, `af_n`=1 and `q`=0. The write order and the read order both restart at the almost-empty offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| mrs_n | input | 1 | Master reset, active low, synchronous |
| ld_n | input | 1 | Strap captured during reset; afterwards enables offset access (active low) |
| sen_n | input | 1 | Serial shift enable, active low |
| sdi | input | 1 | Serial offset bit |
| wr_en | input | 1 | Parallel offset write strobe |
| rd_en | input | 1 | Parallel offset read strobe |
| din | input | OFS_W | Parallel offset write data |
| q | output | OFS_W | Parallel offset readback |
| fill | input | CNT_W | FIFO fill count, 0 to DEPTH |
| ae_n | output | 1 | Almost-empty flag, active low |
| af_n | output | 1 | Almost-full flag, active low |

## Verification
The bound checker runs on every cycle. It checks that `q` holds without a read strobe and that the offsets stay frozen while access is closed or the serial shift is disabled. It also checks that the captured mode never changes after reset, that a zero fill always raises almost-empty, and that a full count always raises almost-full. Only the bench's scenarios can show the rest, because each needs a known history of shifted bits and written words. That covers the reset defaults picked by the strap, the bit and word ordering, the rejection of the unselected path and of excess serial bits, and the exact threshold edges of both flags.

// File: rtl/afl_pkg.sv
package afl_pkg;
   typedef enum logic {
      LM_PARALLEL = 1'b0,
      LM_SERIAL   = 1'b1
   } load_mode_e;

   localparam int unsigned DFLT_OFS_PAR = 127;
   localparam int unsigned DFLT_OFS_SER = 1023;
   localparam int unsigned MIN_OFS_W    = 10;
endpackage

// File: rtl/afl_ofs_bank.sv
module afl_ofs_bank
   import afl_pkg::*;
#(
   parameter int OFS_W = 12
) (
   input  logic             clk,
   input  logic             mrs_n,
   input  logic             ld_n,
   input  logic             sen_n,
   input  logic             sdi,
   input  logic             wr_en,
   input  logic [OFS_W-1:0] din,
   output load_mode_e       mode,
   output logic [OFS_W-1:0] ae_ofs,
   output logic [OFS_W-1:0] af_ofs
);
   localparam int SBITS = 2 * OFS_W;
   localparam int BIT_W = $clog2(SBITS + 1);

   logic [BIT_W-1:0] bit_idx;
   logic             wsel;
   logic             ser_go;
   logic             par_go;

   assign ser_go = (mode == LM_SERIAL) && !sen_n && !ld_n && (bit_idx < BIT_W'(SBITS));
   assign par_go = (mode == LM_PARALLEL) && !ld_n && wr_en;

   always_ff @(posedge clk) begin
      if (!mrs_n) begin
         mode    <= ld_n ? LM_SERIAL : LM_PARALLEL;
         ae_ofs  <= ld_n ? OFS_W'(DFLT_OFS_SER) : OFS_W'(DFLT_OFS_PAR);
         af_ofs  <= ld_n ? OFS_W'(DFLT_OFS_SER) : OFS_W'(DFLT_OFS_PAR);
         bit_idx <= '0;
         wsel    <= 1'b0;
      end else begin
         if (ser_go) begin
            for (int i = 0; i < OFS_W; i++) begin
               if (bit_idx == BIT_W'(i))         ae_ofs[i] <= sdi;
               if (bit_idx == BIT_W'(i + OFS_W)) af_ofs[i] <= sdi;
            end
            bit_idx <= bit_idx + 1'b1;
         end
         if (par_go) begin
            if (!wsel) ae_ofs <= din;
            else       af_ofs <= din;
            wsel <= ~wsel;
         end
      end
   end
endmodule

// File: rtl/afl_readback.sv
module afl_readback #(
   parameter int OFS_W = 12
) (
   input  logic             clk,
   input  logic             mrs_n,
   input  logic             ld_n,
   input  logic             rd_en,
   input  logic [OFS_W-1:0] ae_ofs,
   input  logic [OFS_W-1:0] af_ofs,
   output logic [OFS_W-1:0] q
);
   logic rsel;

   always_ff @(posedge clk) begin
      if (!mrs_n) begin
         q    <= '0;
         rsel <= 1'b0;
      end else if (!ld_n && rd_en) begin
         q    <= rsel ? af_ofs : ae_ofs;
         rsel <= ~rsel;
      end
   end
endmodule

// File: rtl/afl_flag_cmp.sv
module afl_flag_cmp #(
   parameter int DEPTH     = 4096,
   parameter int OFS_W     = 12,
   parameter int CNT_W     = 13,
   parameter bit REG_FLAGS = 1'b1
) (
   input  logic             clk,
   input  logic             mrs_n,
   input  logic [CNT_W-1:0] fill,
   input  logic [OFS_W-1:0] ae_ofs,
   input  logic [OFS_W-1:0] af_ofs,
   output logic             ae_n,
   output logic             af_n
);
   localparam int CMP_W = ((CNT_W > OFS_W) ? CNT_W : OFS_W) + 1;

   logic [CMP_W-1:0] fill_x, ae_x, af_x;
   logic             ae_hit, af_hit;

   assign fill_x = CMP_W'(fill);
   assign ae_x   = CMP_W'(ae_ofs);
   assign af_x   = CMP_W'(af_ofs);
   assign ae_hit = (fill_x <= ae_x);
   assign af_hit = ((fill_x + af_x) >= CMP_W'(DEPTH));

   generate
      if (REG_FLAGS) begin : g_reg
         always_ff @(posedge clk) begin
            if (!mrs_n) begin
               ae_n <= 1'b0;
               af_n <= 1'b1;
            end else begin
               ae_n <= ~ae_hit;
               af_n <= ~af_hit;
            end
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ mrs_n;
         assign ae_n = ~ae_hit;
         assign af_n = ~af_hit;
      end
   endgenerate
endmodule

// File: rtl/afl_offset_loader.sv
module afl_offset_loader
   import afl_pkg::*;
#(
   parameter int  DEPTH     = 4096,
   parameter int  OFS_W     = 12,
   parameter bit  REG_FLAGS = 1'b1,
   localparam int CNT_W     = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             mrs_n,
   input  logic             ld_n,
   input  logic             sen_n,
   input  logic             sdi,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [OFS_W-1:0] din,
   output logic [OFS_W-1:0] q,
   input  logic [CNT_W-1:0] fill,
   output logic             ae_n,
   output logic             af_n
);
   generate
      if (OFS_W < MIN_OFS_W) begin : g_bad_ofs_w
         $error("afl_offset_loader: OFS_W too narrow for default offsets");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("afl_offset_loader: DEPTH must be at least 2");
      end
   endgenerate

   load_mode_e       mode;
   logic [OFS_W-1:0] ae_ofs;
   logic [OFS_W-1:0] af_ofs;

   afl_ofs_bank #(.OFS_W(OFS_W)) u_bank (
      .clk(clk), .mrs_n(mrs_n), .ld_n(ld_n), .sen_n(sen_n), .sdi(sdi),
      .wr_en(wr_en), .din(din), .mode(mode), .ae_ofs(ae_ofs), .af_ofs(af_ofs)
   );

   afl_readback #(.OFS_W(OFS_W)) u_rdbk (
      .clk(clk), .mrs_n(mrs_n), .ld_n(ld_n), .rd_en(rd_en),
      .ae_ofs(ae_ofs), .af_ofs(af_ofs), .q(q)
   );

   afl_flag_cmp #(.DEPTH(DEPTH), .OFS_W(OFS_W), .CNT_W(CNT_W), .REG_FLAGS(REG_FLAGS)) u_cmp (
      .clk(clk), .mrs_n(mrs_n), .fill(fill), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
      .ae_n(ae_n), .af_n(af_n)
   );
endmodule

// File: rtl/afl_chk.sv
module afl_chk #(
   parameter int DEPTH     = 4096,
   parameter int OFS_W     = 12,
   parameter int CNT_W     = 13,
   parameter bit REG_FLAGS = 1'b1
) (
   input logic             clk,
   input logic             mrs_n,
   input logic             ld_n,
   input logic             sen_n,
   input logic             rd_en,
   input logic [CNT_W-1:0] fill,
   input logic             mode,
   input logic [OFS_W-1:0] ae_ofs,
   input logic [OFS_W-1:0] af_ofs,
   input logic [OFS_W-1:0] q,
   input logic             ae_n,
   input logic             af_n
);
   // R8
   q_hold_chk: assert property (@(posedge clk) disable iff (!mrs_n)
      (ld_n || !rd_en) |=> $stable(q));

   // R6
   ld_idle_chk: assert property (@(posedge clk) disable iff (!mrs_n)
      ld_n |=> ($stable(ae_ofs) && $stable(af_ofs)));

   // R4
   ser_hold_chk: assert property (@(posedge clk) disable iff (!mrs_n)
      (mode && sen_n) |=> ($stable(ae_ofs) && $stable(af_ofs)));

   // R7
   mode_fixed_chk: assert property (@(posedge clk) disable iff (!mrs_n)
      mrs_n |=> $stable(mode));

   generate
      if (REG_FLAGS) begin : g_reg_chk
         // R9
         empty_ae_chk: assert property (@(posedge clk) disable iff (!mrs_n)
            (fill == '0) |=> !ae_n);
         // R10
         full_af_chk: assert property (@(posedge clk) disable iff (!mrs_n)
            (fill == CNT_W'(DEPTH)) |=> !af_n);
      end else begin : g_comb_chk
         // R9
         empty_ae_chk: assert property (@(posedge clk) disable iff (!mrs_n)
            (fill == '0) |-> !ae_n);
         // R10
         full_af_chk: assert property (@(posedge clk) disable iff (!mrs_n)
            (fill == CNT_W'(DEPTH)) |-> !af_n);
      end
   endgenerate
endmodule

bind afl_offset_loader afl_chk #(
   .DEPTH(DEPTH), .OFS_W(OFS_W), .CNT_W(CNT_W), .REG_FLAGS(REG_FLAGS)
) u_chk (
   .clk(clk), .mrs_n(mrs_n), .ld_n(ld_n), .sen_n(sen_n), .rd_en(rd_en),
   .fill(fill), .mode(mode), .ae_ofs(ae_ofs), .af_ofs(af_ofs), .q(q),
   .ae_n(ae_n), .af_n(af_n)
);

// File: tb/afl_offset_loader_tb.sv
`timescale 1ns/1ps
module afl_offset_loader_tb;
   localparam int DEPTH = 4096;
   localparam int OFS_W = 12;
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic             clk = 1'b0;
   logic             mrs_n = 1'b0;
   logic             ld_n = 1'b0;
   logic             sen_n = 1'b1;
   logic             sdi = 1'b0;
   logic             wr_en = 1'b0;
   logic             rd_en = 1'b0;
   logic [OFS_W-1:0] din = '0;
   logic [CNT_W-1:0] fill = '0;
   logic [OFS_W-1:0] q;
   logic             ae_n, af_n;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   afl_offset_loader #(.DEPTH(DEPTH), .OFS_W(OFS_W), .REG_FLAGS(1'b1)) u_dut (
      .clk(clk), .mrs_n(mrs_n), .ld_n(ld_n), .sen_n(sen_n), .sdi(sdi),
      .wr_en(wr_en), .rd_en(rd_en), .din(din), .q(q), .fill(fill),
      .ae_n(ae_n), .af_n(af_n)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic strap);
      @(negedge clk);
      mrs_n = 1'b0; ld_n = strap; sen_n = 1'b1; wr_en = 1'b0; rd_en = 1'b0; fill = '0;
      step(); step();
      mrs_n = 1'b1; ld_n = 1'b1;
   endtask

   task automatic read_pair(input string req, input int exp_ae, input int exp_af);
      ld_n = 1'b0; rd_en = 1'b1;
      step();
      chk({req, " readback almost-empty"}, int'(q), exp_ae);
      step();
      chk({req, " readback almost-full"}, int'(q), exp_af);
      rd_en = 1'b0; ld_n = 1'b1;
   endtask

   task automatic par_write(input int val);
      ld_n = 1'b0; wr_en = 1'b1; din = OFS_W'(val);
      step();
      wr_en = 1'b0; ld_n = 1'b1;
   endtask

   task automatic flag_at(input string req, input int f, input int exp_ae, input int exp_af);
      fill = CNT_W'(f);
      step();
      chk({req, " ae_n"}, int'(ae_n), exp_ae);
      chk({req, " af_n"}, int'(af_n), exp_af);
   endtask

   task automatic t_reset_parallel();
      do_reset(1'b0);
      // R11 reset state of outputs
      chk("R11 ae_n", int'(ae_n), 0);
      chk("R11 af_n", int'(af_n), 1);
      chk("R11 q", int'(q), 0);
      // R1 defaults with strap low
      read_pair("R1", 127, 127);
   endtask

   task automatic t_parallel_write();
      par_write(100);
      par_write(200);
      read_pair("R6 first pair", 100, 200);
      par_write(50);
      par_write(300);
      read_pair("R6 wrap", 50, 300);
      // R6 wr_en ignored with ld_n high
      ld_n = 1'b1; wr_en = 1'b1; din = OFS_W'(999);
      step();
      wr_en = 1'b0;
      read_pair("R6 ld_n high", 50, 300);
      // R7 serial bits ignored in parallel mode
      ld_n = 1'b0; sen_n = 1'b0; sdi = 1'b1;
      repeat (8) step();
      sen_n = 1'b1; ld_n = 1'b1;
      read_pair("R7 serial in parallel mode", 50, 300);
      // R8 q holds without a read
      repeat (3) step();
      chk("R8 q hold", int'(q), 300);
   endtask

   task automatic t_flags_parallel();
      flag_at("R9 at offset", 50, 0, 1);
      flag_at("R9 above offset", 51, 1, 1);
      flag_at("R10 below threshold", DEPTH - 300 - 1, 1, 1);
      flag_at("R10 at threshold", DEPTH - 300, 1, 0);
      flag_at("R10 full", DEPTH, 1, 0);
      flag_at("R9 empty", 0, 0, 1);
   endtask

   task automatic t_reset_serial();
      do_reset(1'b1);
      chk("R11 q after reset", int'(q), 0);
      read_pair("R2", 1023, 1023);
      flag_at("R9 default serial at", 1023, 0, 1);
      flag_at("R9 default serial above", 1024, 1, 1);
      flag_at("R10 default serial", DEPTH - 1023, 1, 0);
   endtask

   task automatic t_serial_load();
      logic [OFS_W-1:0] ae_v = OFS_W'(12'h0A5);
      logic [OFS_W-1:0] af_v = OFS_W'(12'h123);
      ld_n = 1'b0;
      for (int i = 0; i < OFS_W; i++) begin
         sen_n = 1'b0; sdi = ae_v[i];
         step();
      end
      // R4 pause with sen_n high while sdi toggles
      sen_n = 1'b1;
      for (int i = 0; i < 4; i++) begin
         sdi = i[0];
         step();
      end
      ld_n = 1'b1;
      read_pair("R4 mid-load", 12'h0A5, 1023);
      ld_n = 1'b0;
      for (int i = 0; i < OFS_W; i++) begin
         sen_n = 1'b0; sdi = af_v[i];
         step();
      end
      // R5 extra bits ignored
      sdi = 1'b1;
      repeat (5) step();
      sen_n = 1'b1; ld_n = 1'b1;
      read_pair("R3 R5 serial result", 12'h0A5, 12'h123);
      // R7 parallel write ignored in serial mode
      par_write(7);
      par_write(9);
      read_pair("R7 parallel in serial mode", 12'h0A5, 12'h123);
      flag_at("R9 serial offset", 12'h0A5, 0, 1);
      flag_at("R10 serial offset", DEPTH - 12'h123, 1, 0);
      flag_at("R10 serial below", DEPTH - 12'h123 - 1, 1, 1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         miscompares++;
         vectors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      t_reset_parallel();
      t_parallel_write();
      t_flags_parallel();
      t_reset_serial();
      t_serial_load();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule